// File: doc/BRIEF.md
# Read-Capture Phase Window Calibrator

This block finds the best sampling phase for a read-capture clock. On a calibration request it first winds a stepping phase shifter forward to step 0. It then visits every step across either one or two memory clock periods. At each step it asks an external read-test engine for a pass or fail verdict and records that verdict in a per-step bitmap.

When the sweep is finished, a scan engine walks the bitmap and finds the longest run of consecutive passing steps. In single-period mode a run may wrap from the last step back to step 0. The block takes the middle of that run as the chosen phase and steps the shifter forward to it. Only after that does it pulse done, together with the chosen phase, the number of passing steps in the run and a fail flag.

The shifter is driven one position per acknowledged request, and only one step or one read is outstanding at a time. The number of steps per memory clock period is the parameter `STEPS`. A double-period sweep uses `2*STEPS` positions.

Top module: `phase_window_cal`

## Requirements
- R1: After reset, `phase_out`, `win_size`, `cal_done`, `cal_fail`, `step_req` and `rd_start` are all 0.
- R2: A calibration tests N positions, where N = `STEPS` when `span_double` is 0 and N = `2*STEPS` when it is 1. It performs exactly N reads, in shifter positions 0, 1, …, N-1 in that order, with one acknowledged step between consecutive reads. The shifter position advances by one per acknowledged step and wraps to 0 when it reaches N or more.
- R3: `step_req` stays high until a cycle in which `step_ack` is high. `rd_start` stays high until a cycle in which `rd_done` is high. The two are never high together.
- R4: Before the first read, the block steps the shifter forward from wherever the previous calibration left it until it reaches position 0.
- R5: The window is the longest run of consecutive passing positions. With `span_double`=0, a run that passes through position N-1 and continues at position 0 counts as one run. With `span_double`=1, no run wraps. If every position passes, the run starts at 0 and has length N.
- R6: Among runs of equal greatest length, the one with the lowest starting position is chosen. For a wrapping run, the starting position is the one just after the fail that precedes it.
- R7: `phase_out` = (start + floor((len-1)/2)) mod N. For an even length this is the lower of the two middle positions.
- R8: `win_size` equals the length of the chosen run, from 1 to N, whenever at least one position passed.
- R9: If no position passes, `cal_fail` is 1, `win_size` is 0 and `phase_out` is 0, and the shifter is parked at position 0. Otherwise `cal_fail` is 0.
- R10: `cal_done` is a one-cycle pulse, raised only once the shifter stands at `phase_out`. The outputs hold until the next done. A `cal_start` while a calibration is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Begin a calibration when idle |
| span_double | input | 1 | 0: sweep one memory clock period, 1: two periods |
| step_req | output | 1 | Request one shifter step |
| step_ack | input | 1 | Shifter moved one position |
| rd_start | output | 1 | Request a test read at the current phase |
| rd_done | input | 1 | Test read finished |
| rd_pass | input | 1 | Read data matched, valid with `rd_done` |
| cal_done | output | 1 | One-cycle calibration complete pulse |
| cal_fail | output | 1 | No passing position found |
| phase_out | output | $clog2(2*STEPS) | Chosen phase in steps from position 0 |
| win_size | output | $clog2(2*STEPS)+1 | Passing positions in the chosen run |

## Verification
The assertions assume that `step_ack` is a single-cycle pulse given only while `step_req` is high. They assume the same of `rd_done` with respect to `rd_start`. They also assume that `span_double` does not change during a calibration. The bench models the shifter and the read engine as responders that wait for a high request, add a random delay of zero to two cycles, and then answer with one pulse. The bench changes the span only between calibrations, so the stimulus stays inside those assumptions. The pass patterns are directed wrap, tie, even-length and empty cases, plus random sets of passing runs.

// File: rtl/phase_cal_pkg.sv
package phase_cal_pkg;
  typedef enum logic [2:0] {
    CS_IDLE,
    CS_HOME,
    CS_READ,
    CS_STEP,
    CS_SCAN,
    CS_PARK
  } cal_state_t;
endpackage

// File: rtl/pcal_seek.sv
module pcal_seek #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [PW-1:0] target,
  input  logic [PW:0]   n_pos,
  output logic          step_req,
  input  logic          step_ack,
  output logic [PW-1:0] cur,
  output logic          done
);
  logic          busy;
  logic [PW-1:0] tgt;
  logic [PW:0]   nxt;

  assign nxt = {1'b0, cur} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tgt      <= '0;
      cur      <= '0;
      step_req <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        tgt  <= target;
      end else if (busy) begin
        if (step_req) begin
          if (step_ack) begin
            step_req <= 1'b0;
            cur      <= (nxt >= n_pos) ? '0 : nxt[PW-1:0];
          end
        end else if (cur == tgt) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step_req <= 1'b1;
        end
      end
    end
  end

  // R3: a step request is held until acknowledged
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    step_req && !step_ack |=> step_req);

  // R2: each acknowledged step moves the position by exactly one or wraps
  p_one_pos_r2: assert property (@(posedge clk) disable iff (rst)
    step_req && step_ack |=> (cur == '0) || (cur == $past(cur) + 1'b1));
endmodule

// File: rtl/pcal_window_scan.sv
module pcal_window_scan #(
  parameter int MAXP = 32,
  parameter int PW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            wrap,
  input  logic [PW:0]     n_pos,
  input  logic [MAXP-1:0] pmap,
  output logic            done,
  output logic [PW:0]     len,
  output logic [PW-1:0]   centre
);
  logic            busy;
  logic [PW+1:0]   k;
  logic [PW+1:0]   limit;
  logic [PW+1:0]   idx_w;
  logic [PW-1:0]   idx;
  logic [PW:0]     run, nrun, best;
  logic [PW-1:0]   bend;
  logic [PW+1:0]   s_raw, s_mod, c_raw;

  assign limit = wrap ? ({1'b0, n_pos} << 1) - 1'b1 : {1'b0, n_pos} - 1'b1;
  assign idx_w = (k >= {1'b0, n_pos}) ? k - {1'b0, n_pos} : k;
  assign idx   = idx_w[PW-1:0];

  always_comb begin
    if (pmap[idx])
      nrun = (run == n_pos) ? run : run + 1'b1;
    else
      nrun = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      k    <= '0;
      run  <= '0;
      best <= '0;
      bend <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        k    <= '0;
        run  <= '0;
        best <= '0;
        bend <= '0;
      end else if (busy) begin
        run <= nrun;
        if (nrun > best) begin
          best <= nrun;
          bend <= idx;
        end
        if (k == limit) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          k <= k + 1'b1;
        end
      end
    end
  end

  // start = end + 1 - len (mod N), centre = start + (len-1)/2 (mod N)
  assign s_raw  = {2'b0, bend} + {1'b0, n_pos} + 1'b1 - {1'b0, best};
  assign s_mod  = (s_raw >= {1'b0, n_pos}) ? s_raw - {1'b0, n_pos} : s_raw;
  assign c_raw  = s_mod + {2'b0, (best - 1'b1) >> 1};
  assign len    = best;
  assign centre = (c_raw >= {1'b0, n_pos}) ? c_raw[PW-1:0] - n_pos[PW-1:0]
                                           : c_raw[PW-1:0];

  // R8: the run length never exceeds the number of positions
  p_len_bound_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> best <= n_pos);

  // R5: the scan index always addresses a swept position
  p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
    busy && !go |-> {1'b0, idx} < n_pos);
endmodule

// File: rtl/phase_window_cal.sv
module phase_window_cal
  import phase_cal_pkg::*;
#(
  parameter int STEPS = 16,
  localparam int MAXP = 2 * STEPS,
  localparam int PW   = $clog2(MAXP),
  localparam int SW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cal_start,
  input  logic          span_double,
  output logic          step_req,
  input  logic          step_ack,
  output logic          rd_start,
  input  logic          rd_done,
  input  logic          rd_pass,
  output logic          cal_done,
  output logic          cal_fail,
  output logic [PW-1:0] phase_out,
  output logic [SW-1:0] win_size
);
  cal_state_t      st;
  logic [PW:0]     n_pos;
  logic            wrap_r;
  logic [PW-1:0]   pos;
  logic [MAXP-1:0] pmap;
  logic            sk_go, sk_done;
  logic [PW-1:0]   sk_tgt, sk_cur;
  logic            sc_go, sc_done;
  logic [PW:0]     sc_len, res_len;
  logic [PW-1:0]   sc_centre, res_ph;

  pcal_seek #(.PW(PW)) u_seek (
    .clk(clk), .rst(rst), .go(sk_go), .target(sk_tgt), .n_pos(n_pos),
    .step_req(step_req), .step_ack(step_ack), .cur(sk_cur), .done(sk_done)
  );

  pcal_window_scan #(.MAXP(MAXP), .PW(PW)) u_scan (
    .clk(clk), .rst(rst), .go(sc_go), .wrap(wrap_r), .n_pos(n_pos),
    .pmap(pmap), .done(sc_done), .len(sc_len), .centre(sc_centre)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CS_IDLE;
      n_pos     <= SW'(STEPS);
      wrap_r    <= 1'b1;
      pos       <= '0;
      pmap      <= '0;
      sk_go     <= 1'b0;
      sk_tgt    <= '0;
      sc_go     <= 1'b0;
      res_len   <= '0;
      res_ph    <= '0;
      rd_start  <= 1'b0;
      cal_done  <= 1'b0;
      cal_fail  <= 1'b0;
      phase_out <= '0;
      win_size  <= '0;
    end else begin
      sk_go    <= 1'b0;
      sc_go    <= 1'b0;
      cal_done <= 1'b0;
      case (st)
        CS_IDLE: if (cal_start) begin
          n_pos  <= span_double ? SW'(MAXP) : SW'(STEPS);
          wrap_r <= !span_double;
          sk_tgt <= '0;
          sk_go  <= 1'b1;
          st     <= CS_HOME;
        end
        CS_HOME: if (sk_done) begin
          pos      <= '0;
          rd_start <= 1'b1;
          st       <= CS_READ;
        end
        CS_READ: if (rd_done) begin
          rd_start  <= 1'b0;
          pmap[pos] <= rd_pass;
          if ({1'b0, pos} == n_pos - 1'b1) begin
            sc_go <= 1'b1;
            st    <= CS_SCAN;
          end else begin
            sk_tgt <= pos + 1'b1;
            sk_go  <= 1'b1;
            st     <= CS_STEP;
          end
        end
        CS_STEP: if (sk_done) begin
          pos      <= pos + 1'b1;
          rd_start <= 1'b1;
          st       <= CS_READ;
        end
        CS_SCAN: if (sc_done) begin
          res_len <= sc_len;
          res_ph  <= (sc_len == '0) ? '0 : sc_centre;
          sk_tgt  <= (sc_len == '0) ? '0 : sc_centre;
          sk_go   <= 1'b1;
          st      <= CS_PARK;
        end
        CS_PARK: if (sk_done) begin
          cal_done  <= 1'b1;
          phase_out <= res_ph;
          win_size  <= res_len;
          cal_fail  <= (res_len == '0);
          st        <= CS_IDLE;
        end
        default: st <= CS_IDLE;
      endcase
    end
  end

  // R3: a read request is held until the engine answers
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    rd_start && !rd_done |=> rd_start);

  // R3: never a step and a read outstanding together
  p_single_flight_r3: assert property (@(posedge clk) disable iff (rst)
    !(step_req && rd_start));

  // R10: done only once the shifter stands at the reported phase
  p_parked_r10: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> sk_cur == phase_out);

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> !cal_done);

  // R9: the fail flag goes with a zero size and phase 0
  p_fail_zero_r9: assert property (@(posedge clk) disable iff (rst)
    cal_done && cal_fail |-> win_size == '0 && phase_out == '0);

  // R8: a successful calibration reports a size within 1..N
  p_size_range_r8: assert property (@(posedge clk) disable iff (rst)
    cal_done && !cal_fail |-> win_size != '0 && win_size <= n_pos);
endmodule

// File: tb/tb_phase_window_cal.sv
module tb_phase_window_cal;
  localparam int STEPS = 16;
  localparam int MAXP  = 2 * STEPS;
  localparam int PW    = $clog2(MAXP);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, cal_start, span_double, step_ack, rd_done, rd_pass;
  logic step_req, rd_start, cal_done, cal_fail;
  logic [PW-1:0] phase_out;
  logic [PW:0]   win_size;

  int vec = 0, errs = 0;
  int shp = 0, ncur = STEPS, rdidx = 0;
  logic [63:0] pat = '0;
  bit finished = 1'b0;

  phase_window_cal #(.STEPS(STEPS)) dut (
    .clk(clk), .rst(rst), .cal_start(cal_start), .span_double(span_double),
    .step_req(step_req), .step_ack(step_ack), .rd_start(rd_start),
    .rd_done(rd_done), .rd_pass(rd_pass), .cal_done(cal_done),
    .cal_fail(cal_fail), .phase_out(phase_out), .win_size(win_size)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // shifter model: one position per acknowledged request
  initial begin
    step_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst && step_req) begin
        chk(!rd_start, "R3 step and read together", 1, 0);
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk(step_req, "R3 step_req dropped before ack", 0, 1);
        end
        step_ack = 1'b1;
        @(negedge clk);
        step_ack = 1'b0;
        shp = (shp + 1 >= ncur) ? 0 : shp + 1;
      end
    end
  end

  // read engine model: verdict from the pattern at the shifter position
  initial begin
    rd_done = 1'b0;
    rd_pass = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst && rd_start) begin
        chk(shp == rdidx, "R2 read position order", shp, rdidx);
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk(rd_start, "R3 rd_start dropped before done", 0, 1);
        end
        rd_pass = pat[shp];
        rd_done = 1'b1;
        rdidx++;
        @(negedge clk);
        rd_done = 1'b0;
        rd_pass = 1'b0;
      end
    end
  end

  function automatic void exp_win(input logic [63:0] p, input int n, input bit wrap,
                                  output int len, output int st);
    bit all = 1'b1;
    len = 0;
    st  = 0;
    for (int i = 0; i < n; i++) if (!p[i]) all = 1'b0;
    if (all) begin
      len = n;
      return;
    end
    for (int s = 0; s < n; s++) begin
      bit is_start;
      int l;
      if (wrap) is_start = p[s] && !p[(s + n - 1) % n];
      else      is_start = p[s] && (s == 0 || !p[s - 1]);
      if (is_start) begin
        l = 0;
        while (l < n && (wrap || s + l < n) && p[(s + l) % n]) l++;
        if (l > len) begin
          len = l;
          st  = s;
        end
      end
    end
  endfunction

  task automatic run_cal(input bit dbl, input logic [63:0] p, input bit poke, input string tag);
    int t, len, st, ctr;
    span_double = dbl;
    ncur  = dbl ? MAXP : STEPS;
    pat   = p;
    rdidx = 0;
    @(negedge clk);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    t = 0;
    while (!cal_done && t < 20000) begin
      @(negedge clk);
      t++;
      cal_start = (poke && (t == 5 || t == 40));
    end
    cal_start = 1'b0;
    if (!cal_done) begin
      chk(1'b0, {"R10 done never seen ", tag}, 0, 1);
      return;
    end
    exp_win(p, ncur, !dbl, len, st);
    ctr = (len == 0) ? 0 : (st + (len - 1) / 2) % ncur;
    chk(rdidx == ncur, {"R2 read count ", tag}, rdidx, ncur);
    chk(int'(phase_out) == ctr, {"R7 phase ", tag}, phase_out, ctr);
    chk(int'(win_size) == len, {"R8 size ", tag}, win_size, len);
    chk(cal_fail == (len == 0), {"R9 fail flag ", tag}, cal_fail, len == 0);
    chk(shp == ctr, {"R10 shifter parked ", tag}, shp, ctr);
    @(negedge clk);
    chk(!cal_done, {"R10 done pulse width ", tag}, cal_done, 0);
    chk(int'(phase_out) == ctr, {"R10 phase held ", tag}, phase_out, ctr);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errs++;
      vec++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1;
    cal_start = 1'b0;
    span_double = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(phase_out == '0, "R1 phase_out", phase_out, 0);
    chk(win_size == '0, "R1 win_size", win_size, 0);
    chk(!cal_done && !cal_fail, "R1 done/fail", cal_done, 0);
    chk(!step_req && !rd_start, "R1 requests", step_req, 0);

    run_cal(1'b0, 64'h0, 1'b0, "R9 none pass");
    run_cal(1'b0, 64'hFFFF, 1'b0, "R5 all pass single");
    run_cal(1'b1, 64'hFFFF_FFFF, 1'b0, "R5 all pass double");
    run_cal(1'b0, 64'hC007, 1'b0, "R5 wrap run");
    run_cal(1'b1, 64'hC000_0007, 1'b0, "R5 no wrap in double");
    run_cal(1'b0, 64'h0E1C, 1'b0, "R6 tie lowest start");
    run_cal(1'b0, 64'h00F0, 1'b0, "R7 even length");
    run_cal(1'b0, 64'h8000, 1'b0, "R8 single pass at top");
    run_cal(1'b1, 64'h0FF0_0038, 1'b1, "R10 start ignored double");
    run_cal(1'b0, 64'h0, 1'b1, "R4 home after fail");
    run_cal(1'b0, 64'h3C00, 1'b0, "R4 home from zero");

    for (int r = 0; r < 24; r++) begin
      bit dbl;
      int n, nr;
      logic [63:0] p;
      dbl = $urandom % 2;
      n   = dbl ? MAXP : STEPS;
      nr  = $urandom % 4;
      p   = '0;
      for (int j = 0; j < nr; j++) begin
        int s0, l0;
        s0 = $urandom % n;
        l0 = 1 + $urandom % (n / 2);
        for (int b = 0; b < l0; b++) p[(s0 + b) % n] = 1'b1;
      end
      run_cal(dbl, p, ($urandom % 4) == 0, "R5 random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule